// File: doc/BRIEF.md
# ADC Sample Word Packer with Refresh-Tolerant Burst Buffer

This block takes a stream of converter samples, one per clock when valid, and gathers them into 64-bit memory words. In byte mode eight samples make one word. In the two halfword modes four samples make one word. Complete words are queued in a small word buffer. A burst writer empties that buffer toward a simple memory write port with a valid/ready handshake. The port may hold ready low at any time, for example during refresh, and the buffer hides those pauses.

A capture starts with a one-cycle arm pulse and ends with a one-cycle stop pulse. On stop, any partly filled word is padded with zeros and queued. Every buffered word is then written out, after which a done flag rises and the word counter holds the number of words written. If a word completes while the buffer is full, that word is dropped and a sticky overflow flag is raised.

Top module: `sample_packer`

## Requirements
- R1: After reset, mem_wr_valid, overflow and done are 0 and word_count is 0.
- R2: Mode 2'b00 (byte mode) packs eight samples per word. The k-th sample of a word (k = 0..7, in arrival order) is taken from smp_data[7:0] and placed at bits [8k+7:8k].
- R3: Mode 2'b01 (14-bit mode) packs four samples per word. The k-th sample (k = 0..3) is placed at bits [16k+15:16k] as smp_data[13:0] zero-extended to 16 bits.
- R4: Modes 2'b10 and 2'b11 (16-bit mode) pack four samples per word, with the full smp_data[15:0] placed at bits [16k+15:16k].
- R5: The write address is 0 for the first word after arm and rises by one for each accepted write (mem_wr_valid and mem_wr_ready both high). word_count equals the number of accepted writes.
- R6: While capturing, no write is presented until at least 8 words are buffered. A burst of 8 words is then presented.
- R7: While mem_wr_valid is high and mem_wr_ready is low, valid, address and data hold their values.
- R8: If a word completes while 16 words are buffered, that word is dropped and overflow is set. overflow stays set until the next arm. Words already buffered are still written.
- R9: On stop, a partial word is queued with zeros in its unfilled lanes, and all buffered words are written without regard to the burst size. done rises afterwards. A sample presented in the stop cycle, or while not capturing, is ignored.
- R10: An arm pulse while idle clears overflow, done and word_count and starts a new capture in the selected mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample and memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Packing mode, latched on arm |
| arm | input | 1 | Start pulse, honoured only when idle |
| stop | input | 1 | End pulse, honoured only while capturing |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_data | input | 16 | Sample value |
| mem_wr_valid | output | 1 | A memory word is offered |
| mem_wr_ready | input | 1 | Memory accepts the offered word |
| mem_wr_addr | output | ADDR_W | Word address of the offered word |
| mem_wr_data | output | 64 | Offered memory word |
| overflow | output | 1 | Sticky: a completed word was dropped |
| word_count | output | ADDR_W | Words written since arm |
| done | output | 1 | Capture finished and buffer empty |

## Verification
The assertions assume that arm and stop are one-cycle pulses, that arm comes only while idle, and that mode is steady around the arm pulse. The bench drives every control at the falling edge and pulses arm only after done, or once after reset. Memory stalls come from three patterns, all driven at the falling edge: always ready, a periodic 3-of-7 refusal, and a full stall that is lifted only after stop. Because ready never depends on valid, a held word stays on the port for as long as the stall lasts.

// File: rtl/sample_packer.sv
module sample_packer #(
  parameter int WORD_W = 64,
  parameter int DEPTH  = 16,
  parameter int BURST  = 8,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              arm,
  input  logic              stop,
  input  logic              smp_valid,
  input  logic [15:0]       smp_data,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [WORD_W-1:0] mem_wr_data,
  output logic              overflow,
  output logic [ADDR_W-1:0] word_count,
  output logic              done
);
  localparam int NLANES = WORD_W / 8;
  localparam int WLANES = WORD_W / 16;
  localparam int LW     = $clog2(NLANES);
  localparam int PW     = $clog2(DEPTH);
  localparam int CW     = PW + 1;
  localparam int SHW    = $clog2(WORD_W);
  localparam int BW     = $clog2(BURST + 1);

  typedef enum logic [1:0] {IDLE, RUN, FLUSH} st_t;
  st_t st;

  logic [1:0]        mode_q;
  logic [LW-1:0]     lane;
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] fifo [DEPTH];
  logic [PW-1:0]     wp, rp;
  logic [CW-1:0]     fcnt;
  logic [BW-1:0]     bleft;

  wire              wide      = mode_q != 2'd0;
  wire [LW-1:0]     last_lane = wide ? LW'(WLANES - 1) : LW'(NLANES - 1);
  wire [15:0]       ext       = !wide ? {8'h00, smp_data[7:0]} :
                                (mode_q == 2'd1) ? {2'b00, smp_data[13:0]} : smp_data;
  wire [SHW-1:0]    shamt     = wide ? SHW'({lane, 4'b0000}) : SHW'({lane, 3'b000});
  wire [WORD_W-1:0] merged    = acc | (WORD_W'(ext) << shamt);
  wire              take      = (st == RUN) && smp_valid && !stop;
  wire              word_done = take && (lane == last_lane);
  wire              partial   = (st == RUN) && stop && (lane != '0);
  wire              push      = word_done || partial;
  wire              full      = fcnt == CW'(DEPTH);
  wire              wr_ok     = push && !full;
  wire              pop       = mem_wr_valid && mem_wr_ready;

  assign mem_wr_valid = (fcnt != '0) && ((bleft != '0) || (st == FLUSH));
  assign mem_wr_data  = fifo[rp];

  always_ff @(posedge clk)
    if (wr_ok) fifo[wp] <= word_done ? merged : acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= IDLE;
      mode_q      <= 2'd0;
      lane        <= '0;
      acc         <= '0;
      wp          <= '0;
      rp          <= '0;
      fcnt        <= '0;
      bleft       <= '0;
      mem_wr_addr <= '0;
      word_count  <= '0;
      overflow    <= 1'b0;
      done        <= 1'b0;
    end else begin
      if (st == RUN && stop) begin
        lane <= '0;
        acc  <= '0;
      end else if (take) begin
        if (word_done) begin
          lane <= '0;
          acc  <= '0;
        end else begin
          lane <= lane + 1'b1;
          acc  <= merged;
        end
      end

      if (push && full) overflow <= 1'b1;
      if (wr_ok) wp <= wp + 1'b1;
      if (pop)   rp <= rp + 1'b1;
      if (wr_ok && !pop)      fcnt <= fcnt + 1'b1;
      else if (!wr_ok && pop) fcnt <= fcnt - 1'b1;

      if (pop) begin
        mem_wr_addr <= mem_wr_addr + 1'b1;
        word_count  <= word_count + 1'b1;
      end

      if (pop && bleft != '0)
        bleft <= bleft - 1'b1;
      else if (st == RUN && bleft == '0 && fcnt >= CW'(BURST))
        bleft <= BW'(BURST);

      case (st)
        IDLE: if (arm) begin
          st          <= RUN;
          mode_q      <= mode;
          mem_wr_addr <= '0;
          word_count  <= '0;
          overflow    <= 1'b0;
          done        <= 1'b0;
        end
        RUN: if (stop) st <= FLUSH;
        FLUSH: if (fcnt == '0) begin
          st   <= IDLE;
          done <= 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sample_packer_chk.sv
module sample_packer_chk #(
  parameter int WORD_W = 64,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [WORD_W-1:0] mem_wr_data,
  input logic              overflow,
  input logic [ADDR_W-1:0] word_count,
  input logic              done
);
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_data) && $stable(mem_wr_addr)); // R7
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && mem_wr_ready |=> mem_wr_addr == $past(mem_wr_addr) + 1'b1); // R5
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && mem_wr_ready |=> word_count == $past(word_count) + 1'b1); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !arm |=> overflow); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_wr_valid); // R9
  AST_ARM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    done && arm |=> !overflow && !done && word_count == '0); // R10
endmodule

bind sample_packer sample_packer_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_sample_packer.sv
module sim_sample_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        arm = 1'b0, stop = 1'b0, smp_valid = 1'b0;
  logic [15:0] smp_data = 16'h0;
  logic        mem_wr_valid, mem_wr_ready;
  logic [23:0] mem_wr_addr, word_count;
  logic [63:0] mem_wr_data;
  logic        overflow, done;

  int tests = 0, fails = 0, cyc = 0, wr_seen = 0, rdy_mode = 0;
  logic [63:0] bmem [64];

  always #2 clk = ~clk;

  sample_packer u0 (.*);

  always @(posedge clk) begin
    cyc++;
    if (mem_wr_valid && mem_wr_ready) begin
      bmem[mem_wr_addr[5:0]] <= mem_wr_data;
      wr_seen <= wr_seen + 1;
    end
  end

  always @(negedge clk)
    mem_wr_ready <= (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? ((cyc % 7) >= 3) : 1'b0;

  function automatic logic [15:0] sval(int k, int salt);
    return 16'((k * 97 + salt * 131 + 16'hA5C3) ^ (k << 11));
  endfunction

  function automatic logic [63:0] exp_word(logic [1:0] m, int w, int n, int salt);
    logic [63:0] r = '0;
    int lanes = (m == 2'd0) ? 8 : 4;
    for (int j = 0; j < lanes; j++) begin
      int k = w * lanes + j;
      logic [15:0] v = (k < n) ? sval(k, salt) : 16'h0;
      if (m == 2'd0)      r[8*j +: 8]   = v[7:0];
      else if (m == 2'd1) r[16*j +: 16] = {2'b00, v[13:0]};
      else                r[16*j +: 16] = v;
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_arm(logic [1:0] m);
    @(negedge clk); mode = m; arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic feed(int n, int salt);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); smp_valid = 1'b1; smp_data = sval(k, salt);
    end
    @(negedge clk); smp_valid = 1'b0;
  endtask

  task automatic do_stop(bit junk);
    @(negedge clk); stop = 1'b1; smp_valid = junk; smp_data = 16'hFFFF;
    @(negedge clk); stop = 1'b0; smp_valid = 1'b0;
  endtask

  task automatic wait_done(string req);
    int t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    check(done == 1'b1, req, done, 1);
  endtask

  task automatic check_mem(logic [1:0] m, int nw, int n, int salt, string req);
    for (int w = 0; w < nw; w++)
      check(bmem[w] == exp_word(m, w, n, salt), req, bmem[w], exp_word(m, w, n, salt));
  endtask

  task automatic t_reset;
    check(mem_wr_valid == 1'b0, "R1 valid", mem_wr_valid, 0);
    check(overflow == 1'b0, "R1 overflow", overflow, 0);
    check(word_count == 0, "R1 count", word_count, 0);
    check(done == 1'b0, "R1 done", done, 0);
  endtask

  task automatic t_byte;
    int s;
    rdy_mode = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); smp_valid = 1'b1; smp_data = 16'h00EE;
    end
    @(negedge clk); smp_valid = 1'b0;
    do_arm(2'd0);
    s = wr_seen;
    feed(16, 1);
    repeat (4) @(negedge clk);
    check(wr_seen == s, "R6 no write below burst", wr_seen - s, 0);
    do_stop(1'b0);
    wait_done("R9 byte done");
    check(word_count == 2, "R5 byte count", word_count, 2);
    check_mem(2'd0, 2, 16, 1, "R2 byte packing");
  endtask

  task automatic t_half16;
    int s;
    rdy_mode = 0;
    do_arm(2'd2);
    s = wr_seen;
    feed(40, 2);
    repeat (12) @(negedge clk);
    check(wr_seen - s == 8, "R6 one burst of 8", wr_seen - s, 8);
    do_stop(1'b0);
    wait_done("R9 half16 done");
    check(word_count == 10, "R5 half16 count", word_count, 10);
    check_mem(2'd2, 10, 40, 2, "R4 16-bit packing");
  endtask

  task automatic t_half14;
    rdy_mode = 0;
    do_arm(2'd1);
    feed(12, 3);
    do_stop(1'b0);
    wait_done("R9 14-bit done");
    check(word_count == 3, "R5 14-bit count", word_count, 3);
    check_mem(2'd1, 3, 12, 3, "R3 14-bit zero extend");
  endtask

  task automatic t_partial;
    rdy_mode = 0;
    do_arm(2'd0);
    feed(11, 4);
    do_stop(1'b1);
    wait_done("R9 partial done");
    check(word_count == 2, "R9 partial count", word_count, 2);
    check_mem(2'd0, 2, 11, 4, "R9 zero padding");
  endtask

  task automatic t_stall;
    rdy_mode = 1;
    do_arm(2'd0);
    feed(400, 5);
    do_stop(1'b0);
    wait_done("R7 stalled done");
    check(overflow == 1'b0, "R7 no loss under stalls", overflow, 0);
    check(word_count == 50, "R7 stalled count", word_count, 50);
    check_mem(2'd0, 50, 400, 5, "R7 stalled data");
    rdy_mode = 0;
  endtask

  task automatic t_overflow;
    rdy_mode = 2;
    do_arm(2'd0);
    feed(160, 6);
    check(overflow == 1'b1, "R8 overflow set", overflow, 1);
    do_stop(1'b0);
    rdy_mode = 0;
    wait_done("R8 overflow done");
    check(overflow == 1'b1, "R8 overflow sticky", overflow, 1);
    check(word_count == 16, "R8 kept words", word_count, 16);
    check_mem(2'd0, 16, 128, 6, "R8 kept data");
  endtask

  task automatic t_rearm;
    do_arm(2'd0);
    check(overflow == 1'b0, "R10 overflow cleared", overflow, 0);
    check(done == 1'b0, "R10 done cleared", done, 0);
    check(word_count == 0, "R10 count cleared", word_count, 0);
    do_stop(1'b0);
    wait_done("R9 empty capture done");
    check(word_count == 0, "R9 empty capture count", word_count, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte();
    t_half16();
    t_half14();
    t_partial();
    t_stall();
    t_overflow();
    t_rearm();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule